// File: doc/BRIEF.md
# Thermal Throttle Control Logic

This block decides, for a device with several cores, when thermal control must engage, which throttle path it takes, and when the device must shut down for good. It watches one over-temperature flag and one catastrophic-trip flag per core. It also shares a single processor-hot wire with the rest of the board. The block pulls the wire active when any of its own cores is too hot. It reads the wire back to learn when some other agent, such as a voltage regulator, wants the device throttled.

Thermal control can be triggered from two places, and each takes its own path. An internal over-temperature engages control only on the cores that report it, and only while the thermal-monitor enable is set. Those cores get clock modulation. An external assertion of the shared wire engages control on every core together and requests the lowest frequency and voltage operating point at once, with clock modulation kept off. A catastrophic trip latches a shutdown request that only reset clears. The trip point is fixed by the sensors and cannot be configured.

Top module: `thermal_guard`

## Requirements
- R1: `hot_pin_drive_o` equals the OR of all bits of `core_hot_i` sampled on the previous clock edge, whatever `tm_enable_i` is set to.
- R2: Once an external assertion of the shared wire (`hot_pin_sense_i` = 1 while the block is not driving it) passes through the synchroniser, every bit of `tcc_core_o` is 1. This happens on the third rising edge after the wire changes, and the outputs are still unchanged after the second edge.
- R3: `min_op_req_o` is 1 on exactly the cycles when the external trigger is in effect, with the same timing as R2. An internal over-temperature alone never sets it.
- R4: While the external trigger is in effect, every bit of `clk_mod_o` is 0, even if cores report over-temperature and `tm_enable_i` is 1.
- R5: External thermal control stays in effect for as long as the wire is held asserted, including while the block drives the wire itself. It ends on the third rising edge after an external release, provided the block is not driving the wire.
- R6: Without an external trigger, bit i of `tcc_core_o` and bit i of `clk_mod_o` are both 1 one cycle after `core_hot_i[i]` = 1 with `tm_enable_i` = 1. When `tm_enable_i` = 0, both are 0.
- R7: The block's own drive on the wire, and the synchroniser delay after the drive is released, are never taken for an external assertion. `min_op_req_o` stays 0 and `tcc_core_o` stays at its internally caused value.
- R8: Any bit of `core_trip_i` set to 1 makes `trip_shutdown_o` 1 one cycle later, whatever `tm_enable_i` is and whatever throttle state the block is in.
- R9: `trip_shutdown_o` stays at 1 after its cause goes away, and only a reset clears it.
- R10: With synchronous reset `rst` held high, all outputs are 0 after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| core_hot_i | input | NUM_CORES | Per-core flag: the core has reached its maximum safe temperature |
| core_trip_i | input | NUM_CORES | Per-core catastrophic over-temperature flag |
| tm_enable_i | input | 1 | Enables internally caused thermal control and clock modulation |
| hot_pin_sense_i | input | 1 | Level read back from the shared hot wire, 1 = asserted, asynchronous |
| hot_pin_drive_o | output | 1 | Open-drain pull enable for the shared hot wire, 1 = pull active |
| tcc_core_o | output | NUM_CORES | Per-core thermal-control-active indication |
| clk_mod_o | output | NUM_CORES | Per-core clock-modulation enable |
| min_op_req_o | output | 1 | Request to move to the minimum frequency and voltage point |
| trip_shutdown_o | output | 1 | Latched catastrophic shutdown request |

## Verification
Results that depend on core flags or trip flags are due one edge after the stimulus. Results that depend on the shared wire are due on the third edge after it changes: two synchroniser stages plus the output register. The driver task pushes each expected output set into the queue together with the cycle it is due, counted from the cycle the stimulus is applied. The monitor pops and compares entries at the falling edge of exactly that cycle. Extra entries sit one cycle before a wire-driven change, to confirm nothing moves early. Entries several cycles after the block drops its own drive confirm that the read-back loop never looks like an external request.

// File: rtl/thermguard_pkg.sv
package thermguard_pkg;

  // Why a core is under thermal control this cycle.
  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_INTERNAL = 2'd1,
    CAUSE_EXTERNAL = 2'd2
  } cause_e;

  localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/hotpin_sync.sv
// Synchronises the read-back of the shared hot wire and removes the block's
// own pull from it. While our drive is in flight through the synchroniser,
// the last externally qualified decision is held.
module hotpin_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_sense_i,
  input  logic own_drive_i,
  output logic ext_hot_o
);
  localparam int unsigned STAGES =
    (SYNC_STAGES < thermguard_pkg::MIN_SYNC_STAGES) ? thermguard_pkg::MIN_SYNC_STAGES : SYNC_STAGES;

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] drv_hist_q;
  logic              ext_held_q;
  logic              own_masked;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q     <= '0;
      drv_hist_q <= '0;
      ext_held_q <= 1'b0;
    end else begin
      sync_q     <= {sync_q[STAGES-2:0], pin_sense_i};
      drv_hist_q <= {drv_hist_q[STAGES-2:0], own_drive_i};
      ext_held_q <= ext_hot_o;
    end
  end

  // Any drive still travelling through the stages makes the sample ambiguous.
  assign own_masked = |drv_hist_q;
  assign ext_hot_o  = own_masked ? ext_held_q : sync_q[STAGES-1];

  // R7: a fresh external decision can never rise while our own pull is in flight
  p_own_drive_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (own_masked && !ext_held_q) |-> !ext_hot_o);

endmodule

// File: rtl/throttle_core.sv
// Per-core throttle decision with registered outputs.
module throttle_core #(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CORES-1:0] core_hot_i,
  input  logic                 tm_enable_i,
  input  logic                 ext_hot_i,
  output logic                 pin_drive_o,
  output logic [NUM_CORES-1:0] tcc_core_o,
  output logic [NUM_CORES-1:0] clk_mod_o,
  output logic                 min_op_req_o
);
  import thermguard_pkg::*;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    cause_e cause;

    always_comb begin
      if (ext_hot_i)                        cause = CAUSE_EXTERNAL;
      else if (core_hot_i[c] && tm_enable_i) cause = CAUSE_INTERNAL;
      else                                  cause = CAUSE_NONE;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        tcc_core_o[c] <= 1'b0;
        clk_mod_o[c]  <= 1'b0;
      end else begin
        tcc_core_o[c] <= (cause != CAUSE_NONE);
        clk_mod_o[c]  <= (cause == CAUSE_INTERNAL);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_drive_o  <= 1'b0;
      min_op_req_o <= 1'b0;
    end else begin
      pin_drive_o  <= |core_hot_i;
      min_op_req_o <= ext_hot_i;
    end
  end

  // R1: any hot core pulls the wire on the next cycle
  p_pin_follows_hot_r1: assert property (@(posedge clk) disable iff (rst)
    (|core_hot_i) |=> pin_drive_o);
  // R2: an external trigger engages every core together
  p_ext_all_cores_r2: assert property (@(posedge clk) disable iff (rst)
    ext_hot_i |=> (&tcc_core_o));
  // R3: an external trigger requests the minimum operating point
  p_ext_min_op_r3: assert property (@(posedge clk) disable iff (rst)
    ext_hot_i |=> min_op_req_o);
  // R4: no clock modulation on the external path
  p_ext_no_clkmod_r4: assert property (@(posedge clk) disable iff (rst)
    ext_hot_i |=> (clk_mod_o == '0));
  // R6: with the monitor disabled and no external cause, nothing is throttled
  p_tm_off_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!tm_enable_i && !ext_hot_i) |=> (tcc_core_o == '0 && clk_mod_o == '0));
  // R6: modulation is only ever enabled on a core that is under thermal control
  p_clkmod_within_tcc_r6: assert property (@(posedge clk) disable iff (rst)
    ((clk_mod_o & ~tcc_core_o) == '0));

endmodule

// File: rtl/trip_latch.sv
// Sticky catastrophic shutdown. Depends only on the trip flags.
module trip_latch #(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CORES-1:0] core_trip_i,
  output logic                 trip_o
);
  always_ff @(posedge clk) begin
    if (rst) trip_o <= 1'b0;
    else     trip_o <= trip_o | (|core_trip_i);
  end

  // R8: any trip flag shuts the device down one cycle later
  p_trip_sets_r8: assert property (@(posedge clk) disable iff (rst)
    (|core_trip_i) |=> trip_o);
  // R9: the shutdown holds until reset
  p_trip_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    trip_o |=> trip_o);

endmodule

// File: rtl/thermal_guard.sv
module thermal_guard #(
  parameter int unsigned NUM_CORES   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CORES-1:0] core_hot_i,
  input  logic [NUM_CORES-1:0] core_trip_i,
  input  logic                 tm_enable_i,
  input  logic                 hot_pin_sense_i,
  output logic                 hot_pin_drive_o,
  output logic [NUM_CORES-1:0] tcc_core_o,
  output logic [NUM_CORES-1:0] clk_mod_o,
  output logic                 min_op_req_o,
  output logic                 trip_shutdown_o
);
  logic ext_hot;

  hotpin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst         (rst),
    .pin_sense_i (hot_pin_sense_i),
    .own_drive_i (hot_pin_drive_o),
    .ext_hot_o   (ext_hot)
  );

  throttle_core #(.NUM_CORES(NUM_CORES)) u_throttle (
    .clk          (clk),
    .rst          (rst),
    .core_hot_i   (core_hot_i),
    .tm_enable_i  (tm_enable_i),
    .ext_hot_i    (ext_hot),
    .pin_drive_o  (hot_pin_drive_o),
    .tcc_core_o   (tcc_core_o),
    .clk_mod_o    (clk_mod_o),
    .min_op_req_o (min_op_req_o)
  );

  trip_latch #(.NUM_CORES(NUM_CORES)) u_trip (
    .clk         (clk),
    .rst         (rst),
    .core_trip_i (core_trip_i),
    .trip_o      (trip_shutdown_o)
  );

  // R10: reset clears every output on the next edge
  p_reset_clears_r10: assert property (@(posedge clk)
    rst |=> (!hot_pin_drive_o && tcc_core_o == '0 && clk_mod_o == '0 &&
             !min_op_req_o && !trip_shutdown_o));

endmodule

// File: tb/tb_thermal_guard.sv
module tb_thermal_guard;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NC-1:0] core_hot = '0;
  logic [NC-1:0] core_trip = '0;
  logic          tm_en = 1'b0;
  logic          ext_pull = 1'b0;
  logic          pin_sense;
  logic          pin_drive;
  logic [NC-1:0] tcc;
  logic [NC-1:0] clk_mod;
  logic          min_op;
  logic          trip;

  // Shared wire: asserted when either side pulls it.
  assign pin_sense = ext_pull | pin_drive;

  always #4 clk = ~clk;

  thermal_guard #(.NUM_CORES(NC), .SYNC_STAGES(2)) dut (
    .clk             (clk),
    .rst             (rst),
    .core_hot_i      (core_hot),
    .core_trip_i     (core_trip),
    .tm_enable_i     (tm_en),
    .hot_pin_sense_i (pin_sense),
    .hot_pin_drive_o (pin_drive),
    .tcc_core_o      (tcc),
    .clk_mod_o       (clk_mod),
    .min_op_req_o    (min_op),
    .trip_shutdown_o (trip)
  );

  typedef struct {
    int            due;
    logic          drv;
    logic [NC-1:0] tcc;
    logic [NC-1:0] cm;
    logic          mop;
    logic          trp;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int lat, input logic drv, input logic [NC-1:0] t,
                           input logic [NC-1:0] cm, input logic mop, input logic trp,
                           input string tag);
    exp_t e;
    e.due = cyc + lat; e.drv = drv; e.tcc = t; e.cm = cm; e.mop = mop; e.trp = trp; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: compares due entries at the falling edge of their cycle.
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (e.due != cyc || pin_drive !== e.drv || tcc !== e.tcc || clk_mod !== e.cm ||
            min_op !== e.mop || trip !== e.trp) begin
          n_bad++;
          $display("FAIL %s cyc=%0d: actual drv=%b tcc=%b cm=%b min=%b trip=%b expected drv=%b tcc=%b cm=%b min=%b trip=%b",
                   e.tag, cyc, pin_drive, tcc, clk_mod, min_op, trip,
                   e.drv, e.tcc, e.cm, e.mop, e.trp);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual run still going, expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // Driver
  initial begin
    tick(3);
    rst = 1'b0;
    expect_at(1, 0, 4'b0000, 4'b0000, 0, 0, "R10 reset state");
    tick(2);

    // Internal over-temperature on core 2, monitor enabled
    core_hot = 4'b0100; tm_en = 1'b1;
    expect_at(1, 1, 4'b0100, 4'b0100, 0, 0, "R6 internal path");
    expect_at(5, 1, 4'b0100, 4'b0100, 0, 0, "R7 own drive not external");
    tick(6);

    // Monitor disabled: wire still driven, no control
    tm_en = 1'b0; core_hot = 4'b1001;
    expect_at(1, 1, 4'b0000, 4'b0000, 0, 0, "R1 drive with monitor off");
    tick(2);

    core_hot = 4'b0000;
    expect_at(1, 0, 4'b0000, 4'b0000, 0, 0, "R1 drive released");
    expect_at(4, 0, 4'b0000, 4'b0000, 0, 0, "R7 release tail ignored");
    tick(5);

    // External assertion
    tm_en = 1'b1; ext_pull = 1'b1;
    expect_at(2, 0, 4'b0000, 4'b0000, 0, 0, "R2 not before sync");
    expect_at(3, 0, 4'b1111, 4'b0000, 1, 0, "R2 R3 external path");
    tick(4);

    // Internal over-temperature during external control
    core_hot = 4'b0010;
    expect_at(1, 1, 4'b1111, 4'b0000, 1, 0, "R4 no modulation on external");
    expect_at(4, 1, 4'b1111, 4'b0000, 1, 0, "R5 held while both pull");
    tick(5);

    core_hot = 4'b0000;
    expect_at(1, 0, 4'b1111, 4'b0000, 1, 0, "R5 held after own release");
    expect_at(5, 0, 4'b1111, 4'b0000, 1, 0, "R5 still held");
    tick(6);

    // External release
    ext_pull = 1'b0;
    expect_at(2, 0, 4'b1111, 4'b0000, 1, 0, "R5 not before sync");
    expect_at(3, 0, 4'b0000, 4'b0000, 0, 0, "R5 released");
    tick(4);

    // Catastrophic trip with monitor off
    tm_en = 1'b0; core_trip = 4'b0001;
    expect_at(1, 0, 4'b0000, 4'b0000, 0, 1, "R8 trip with monitor off");
    tick(1);
    core_trip = 4'b0000;
    expect_at(4, 0, 4'b0000, 4'b0000, 0, 1, "R9 trip sticky");
    tick(5);

    rst = 1'b1;
    expect_at(1, 0, 4'b0000, 4'b0000, 0, 0, "R9 R10 reset clears trip");
    tick(1);
    rst = 1'b0;
    tick(2);

    while (q.size() > 0) tick(1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule